// File: doc/BRIEF.md
# Dual-Commit Reorder Buffer

This block keeps the program order of in-flight instructions for a two-wide speculative out-of-order core. At issue it reserves up to two consecutive slots per cycle and hands back each slot's index, which the rest of the core uses as the result tag of that instruction. Results broadcast on either of two result buses are captured by tag, marking the matching slot ready.

Each cycle, up to two ready slots leave the buffer from the oldest end, strictly in order. A retiring ALU or load writes the register file through one of two write ports. A retiring store drives the single memory store port, using the address held in its destination field. A retiring branch writes nothing. If that branch was resolved as mispredicted, every younger slot is discarded and allocation restarts directly after it. Slot indices wrap, so a freed slot is reused while older work is still pending.

Top module: `dual_retire_rob`

## Requirements
- R1: After reset the buffer is empty: no register write, no store and no flush is driven, and the next allocation tags are 0 and 1.
- R2: A request for one slot (alloc_req0) or two slots (alloc_req0 and alloc_req1) is granted (alloc_ok high) when that many slots are free. The tags are the tail index and the index after it, modulo DEPTH. alloc_req1 counts only when alloc_req0 is set.
- R3: When fewer slots are free than requested, alloc_ok is low and no slot is written. A full buffer refuses any request.
- R4: A result on either bus whose tag names an occupied non-branch slot stores the data and marks the slot ready, in any order of completion.
- R5: Up to two slots retire per cycle, starting at the oldest one. A ready slot never retires while an older slot is not ready. Port 0 carries the older of two retirements.
- R6: A retiring slot of type ALU (2'd0) or load (2'd1) drives rf_we with the low RW bits of its destination field as rf_idx, its value, and its index as rf_tag.
- R7: A retiring store (type 2'd2) drives st_we with its destination field as address and its value as data, and writes no register.
- R8: At most one store retires per cycle. A store directly behind a retiring store waits one cycle.
- R9: A branch slot (type 2'd3) becomes ready only through the resolution input (br_vld with br_tag). A correctly predicted branch retires with no register write, no store and no flush.
- R10: When a branch resolved with br_mis set retires, flush is high and alloc_ok is low in that cycle. All younger slots are discarded even if ready, and the next allocation tag is the index just after the branch.
- R11: Tags recycle modulo DEPTH: freed slots at the start of the index range are granted again while later slots are still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_req0 | input | 1 | Request first slot |
| alloc_req1 | input | 1 | Request second slot (with alloc_req0) |
| alloc_typ0 | input | 2 | Type of first instruction |
| alloc_typ1 | input | 2 | Type of second instruction |
| alloc_dst0 | input | AW | Destination register or store address, first |
| alloc_dst1 | input | AW | Destination register or store address, second |
| alloc_ok | output | 1 | Request granted this cycle |
| alloc_tag0 | output | TW | Tag for first instruction |
| alloc_tag1 | output | TW | Tag for second instruction |
| cdb_vld0 | input | 1 | Result bus 0 valid |
| cdb_tag0 | input | TW | Result bus 0 tag |
| cdb_dat0 | input | DW | Result bus 0 data |
| cdb_vld1 | input | 1 | Result bus 1 valid |
| cdb_tag1 | input | TW | Result bus 1 tag |
| cdb_dat1 | input | DW | Result bus 1 data |
| br_vld | input | 1 | Branch resolved |
| br_tag | input | TW | Tag of resolved branch |
| br_mis | input | 1 | Branch was mispredicted |
| rf_we0 | output | 1 | Register write, older retirement |
| rf_idx0 | output | RW | Register index, port 0 |
| rf_dat0 | output | DW | Register data, port 0 |
| rf_tag0 | output | TW | Tag of retiring slot, port 0 |
| rf_we1 | output | 1 | Register write, younger retirement |
| rf_idx1 | output | RW | Register index, port 1 |
| rf_dat1 | output | DW | Register data, port 1 |
| rf_tag1 | output | TW | Tag of retiring slot, port 1 |
| st_we | output | 1 | Store to memory |
| st_addr | output | AW | Store address |
| st_dat | output | DW | Store data |
| flush | output | 1 | Mispredicted branch retiring, younger work squashed |

## Verification
Results are broadcast out of order, so that a later slot is ready while the oldest is not. This separates true in-order retirement from retirement of whatever is ready. Paired and single allocations are run at every fill level up to full, which exposes off-by-one errors in the free-slot test. Tags are reused while older slots are still in flight, which exercises the wrap of both pointers. Store-behind-store, store-beside-ALU and branches resolved both ways, with ready younger slots behind the mispredicted one, tell the type-specific retirement actions apart from plain register retirement.

// File: rtl/dual_retire_rob.sv
module dual_retire_rob #(
  parameter int DEPTH = 9,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int RW    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req0,
  input  logic                     alloc_req1,
  input  logic [1:0]               alloc_typ0,
  input  logic [1:0]               alloc_typ1,
  input  logic [AW-1:0]            alloc_dst0,
  input  logic [AW-1:0]            alloc_dst1,
  output logic                     alloc_ok,
  output logic [$clog2(DEPTH)-1:0] alloc_tag0,
  output logic [$clog2(DEPTH)-1:0] alloc_tag1,
  input  logic                     cdb_vld0,
  input  logic [$clog2(DEPTH)-1:0] cdb_tag0,
  input  logic [DW-1:0]            cdb_dat0,
  input  logic                     cdb_vld1,
  input  logic [$clog2(DEPTH)-1:0] cdb_tag1,
  input  logic [DW-1:0]            cdb_dat1,
  input  logic                     br_vld,
  input  logic [$clog2(DEPTH)-1:0] br_tag,
  input  logic                     br_mis,
  output logic                     rf_we0,
  output logic [RW-1:0]            rf_idx0,
  output logic [DW-1:0]            rf_dat0,
  output logic [$clog2(DEPTH)-1:0] rf_tag0,
  output logic                     rf_we1,
  output logic [RW-1:0]            rf_idx1,
  output logic [DW-1:0]            rf_dat1,
  output logic [$clog2(DEPTH)-1:0] rf_tag1,
  output logic                     st_we,
  output logic [AW-1:0]            st_addr,
  output logic [DW-1:0]            st_dat,
  output logic                     flush
);
  localparam int TW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] T_ALU = 2'd0, T_LD = 2'd1, T_ST = 2'd2, T_BR = 2'd3;

  function automatic logic [TW-1:0] nxt(input logic [TW-1:0] x);
    return (x == TW'(DEPTH - 1)) ? '0 : x + 1'b1;
  endfunction

  logic [DEPTH-1:0] e_vld, e_rdy, e_mis;
  logic [1:0]       e_typ [DEPTH];
  logic [AW-1:0]    e_dst [DEPTH];
  logic [DW-1:0]    e_val [DEPTH];

  logic [TW-1:0] head, tail, h1, head_n;
  logic [CW-1:0] cnt, free_n, n_req, n_fire, n_ret;
  logic          fire0, fire1, ret0, ret1, fl0, fl1;
  logic          st0, st1, br0, br1, wr0, wr1;

  assign h1    = nxt(head);
  assign st0   = e_typ[head] == T_ST;
  assign st1   = e_typ[h1] == T_ST;
  assign br0   = e_typ[head] == T_BR;
  assign br1   = e_typ[h1] == T_BR;
  assign wr0   = e_typ[head] == T_ALU || e_typ[head] == T_LD;
  assign wr1   = e_typ[h1] == T_ALU || e_typ[h1] == T_LD;

  assign ret0  = cnt != '0 && e_vld[head] && e_rdy[head];
  assign fl0   = ret0 && br0 && e_mis[head];
  assign ret1  = ret0 && !fl0 && cnt > CW'(1) && e_vld[h1] && e_rdy[h1] && !(st0 && st1);
  assign fl1   = ret1 && br1 && e_mis[h1];
  assign flush = fl0 || fl1;
  assign n_ret = CW'(ret0) + CW'(ret1);
  assign head_n = ret1 ? nxt(h1) : (ret0 ? h1 : head);

  assign free_n     = CW'(DEPTH) - cnt;
  assign n_req      = alloc_req0 ? (alloc_req1 ? CW'(2) : CW'(1)) : '0;
  assign alloc_ok   = !flush && free_n >= n_req;
  assign fire0      = alloc_ok && alloc_req0;
  assign fire1      = fire0 && alloc_req1;
  assign n_fire     = CW'(fire0) + CW'(fire1);
  assign alloc_tag0 = tail;
  assign alloc_tag1 = nxt(tail);

  assign rf_we0  = ret0 && wr0;
  assign rf_idx0 = e_dst[head][RW-1:0];
  assign rf_dat0 = e_val[head];
  assign rf_tag0 = head;
  assign rf_we1  = ret1 && wr1;
  assign rf_idx1 = e_dst[h1][RW-1:0];
  assign rf_dat1 = e_val[h1];
  assign rf_tag1 = h1;

  assign st_we   = (ret0 && st0) || (ret1 && st1);
  assign st_addr = (ret0 && st0) ? e_dst[head] : e_dst[h1];
  assign st_dat  = (ret0 && st0) ? e_val[head] : e_val[h1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      head <= head_n;
      if (flush) begin
        tail <= head_n;
        cnt  <= '0;
      end else begin
        tail <= fire1 ? nxt(nxt(tail)) : (fire0 ? nxt(tail) : tail);
        cnt  <= cnt + n_fire - n_ret;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit0, hit1, hitb, gone, new0, new1;
    assign hit0 = e_vld[i] && e_typ[i] != T_BR && cdb_vld0 && cdb_tag0 == TW'(i);
    assign hit1 = e_vld[i] && e_typ[i] != T_BR && cdb_vld1 && cdb_tag1 == TW'(i);
    assign hitb = e_vld[i] && e_typ[i] == T_BR && br_vld && br_tag == TW'(i);
    assign gone = flush || (ret0 && head == TW'(i)) || (ret1 && h1 == TW'(i));
    assign new0 = fire0 && tail == TW'(i);
    assign new1 = fire1 && nxt(tail) == TW'(i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_vld[i] <= 1'b0;
        e_rdy[i] <= 1'b0;
        e_mis[i] <= 1'b0;
      end else if (gone) begin
        e_vld[i] <= 1'b0;
        e_rdy[i] <= 1'b0;
      end else if (new0 || new1) begin
        e_vld[i] <= 1'b1;
        e_rdy[i] <= 1'b0;
        e_mis[i] <= 1'b0;
      end else if (hit0 || hit1) begin
        e_rdy[i] <= 1'b1;
      end else if (hitb) begin
        e_rdy[i] <= 1'b1;
        e_mis[i] <= br_mis;
      end
    end

    always_ff @(posedge clk) begin
      if (!gone && new0) begin
        e_typ[i] <= alloc_typ0;
        e_dst[i] <= alloc_dst0;
      end else if (!gone && new1) begin
        e_typ[i] <= alloc_typ1;
        e_dst[i] <= alloc_dst1;
      end
      if (!gone && !new0 && !new1) begin
        if (hit1)      e_val[i] <= cdb_dat1;
        else if (hit0) e_val[i] <= cdb_dat0;
      end
    end
  end
endmodule

// File: rtl/drr_checker.sv
module drr_checker #(
  parameter int DEPTH = 9,
  parameter int TW    = 4,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_req0,
  input logic          alloc_ok,
  input logic [TW-1:0] alloc_tag0,
  input logic [TW-1:0] alloc_tag1,
  input logic          rf_we0,
  input logic          rf_we1,
  input logic [TW-1:0] rf_tag0,
  input logic [TW-1:0] rf_tag1,
  input logic          st_we,
  input logic          flush,
  input logic [CW-1:0] cnt
);
  AST_TAG_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_tag1 == ((alloc_tag0 == TW'(DEPTH - 1)) ? '0 : alloc_tag0 + 1'b1)); // R2
  AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_tag0 < TW'(DEPTH)); // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && alloc_req0) |-> !alloc_ok); // R3
  AST_RETIRE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we0 && rf_we1) |-> rf_tag1 == ((rf_tag0 == TW'(DEPTH - 1)) ? '0 : rf_tag0 + 1'b1)); // R5
  AST_FLUSH_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ok); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rf_we0 && !rf_we1 && !st_we && !flush)); // R10
endmodule

bind dual_retire_rob drr_checker #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req0(alloc_req0), .alloc_ok(alloc_ok),
  .alloc_tag0(alloc_tag0), .alloc_tag1(alloc_tag1), .rf_we0(rf_we0), .rf_we1(rf_we1),
  .rf_tag0(rf_tag0), .rf_tag1(rf_tag1), .st_we(st_we), .flush(flush), .cnt(cnt)
);

// File: tb/tb_dual_retire_rob.sv
module tb_dual_retire_rob;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 9, DW = 32, AW = 16, RW = 5, TW = 4;

  logic clk = 0, rst_n = 0;
  logic alloc_req0, alloc_req1;
  logic [1:0] alloc_typ0, alloc_typ1;
  logic [AW-1:0] alloc_dst0, alloc_dst1;
  logic alloc_ok;
  logic [TW-1:0] alloc_tag0, alloc_tag1;
  logic cdb_vld0, cdb_vld1, br_vld, br_mis;
  logic [TW-1:0] cdb_tag0, cdb_tag1, br_tag;
  logic [DW-1:0] cdb_dat0, cdb_dat1;
  logic rf_we0, rf_we1, st_we, flush;
  logic [RW-1:0] rf_idx0, rf_idx1;
  logic [DW-1:0] rf_dat0, rf_dat1, st_dat;
  logic [TW-1:0] rf_tag0, rf_tag1;
  logic [AW-1:0] st_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_retire_rob #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .RW(RW)) dut (.*);

  function automatic logic [DW-1:0] dv(input int t);
    return 32'h1000 + 32'(t) * 17;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    alloc_req0 = 0; alloc_req1 = 0; alloc_typ0 = 0; alloc_typ1 = 0;
    alloc_dst0 = 0; alloc_dst1 = 0;
    cdb_vld0 = 0; cdb_vld1 = 0; cdb_tag0 = 0; cdb_tag1 = 0; cdb_dat0 = 0; cdb_dat1 = 0;
    br_vld = 0; br_tag = 0; br_mis = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr();
  endtask

  task automatic bus(input int t0, input logic [31:0] d0, input int t1, input logic [31:0] d1);
    cdb_vld0 = 1; cdb_tag0 = TW'(t0); cdb_dat0 = d0;
    cdb_vld1 = 1; cdb_tag1 = TW'(t1); cdb_dat1 = d1;
  endtask

  task automatic rfchk(input string req, input int p, input int idx, input logic [31:0] d, input int t);
    if (p == 0) begin
      chk(req, rf_we0, 1); chk(req, rf_idx0, idx); chk(req, rf_dat0, d); chk(req, rf_tag0, t);
    end else begin
      chk(req, rf_we1, 1); chk(req, rf_idx1, idx); chk(req, rf_dat1, d); chk(req, rf_tag1, t);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    alloc_req0 = 1; alloc_req1 = 1; alloc_dst0 = 1; alloc_dst1 = 2;
    #1;
    chk("R1", alloc_ok, 1); chk("R1", alloc_tag0, 0); chk("R1", alloc_tag1, 1);
    chk("R1", rf_we0, 0); chk("R1", st_we, 0); chk("R1", flush, 0);
    tick();
    // R2 paired allocations at every fill level
    for (int k = 1; k < 4; k++) begin
      alloc_req0 = 1; alloc_req1 = 1; alloc_dst0 = AW'(2*k+1); alloc_dst1 = AW'(2*k+2);
      #1;
      chk("R2", alloc_ok, 1); chk("R2", alloc_tag0, 2*k); chk("R2", alloc_tag1, 2*k+1);
      tick();
    end
    // R3 one slot free, two requested
    alloc_req0 = 1; alloc_req1 = 1; #1;
    chk("R3", alloc_ok, 0);
    tick();
    alloc_req0 = 1; alloc_dst0 = 9; #1;
    chk("R3", alloc_ok, 1); chk("R2", alloc_tag0, 8);
    tick();
    alloc_req0 = 1; #1;
    chk("R3", alloc_ok, 0);
    tick();
    // R4 / R5 out-of-order completion
    bus(1, dv(1), 3, dv(3)); #1;
    chk("R5", rf_we0, 0);
    tick();
    cdb_vld0 = 1; cdb_tag0 = 0; cdb_dat0 = dv(0); #1;
    chk("R5", rf_we0, 0);
    tick();
    #1;
    rfchk("R6", 0, 1, dv(0), 0); rfchk("R5", 1, 2, dv(1), 1);
    tick();
    // R11 reuse of freed tags while 2..8 in flight
    alloc_req0 = 1; alloc_req1 = 1; alloc_typ0 = 2'd2; alloc_dst0 = 16'h0200;
    alloc_typ1 = 2'd3; alloc_dst1 = 0;
    bus(2, dv(2), 5, dv(5)); #1;
    chk("R11", alloc_ok, 1); chk("R11", alloc_tag0, 0); chk("R11", alloc_tag1, 1);
    chk("R5", rf_we0, 0);
    tick();
    bus(4, dv(4), 6, dv(6)); #1;
    rfchk("R5", 0, 3, dv(2), 2); rfchk("R4", 1, 4, dv(3), 3);
    tick();
    bus(7, dv(7), 8, dv(8)); #1;
    rfchk("R5", 0, 5, dv(4), 4); rfchk("R4", 1, 6, dv(5), 5);
    tick();
    cdb_vld0 = 1; cdb_tag0 = 0; cdb_dat0 = 32'hCAFE0001; #1;
    rfchk("R5", 0, 7, dv(6), 6); rfchk("R5", 1, 8, dv(7), 7);
    tick();
    // R7 store beside register write
    br_vld = 1; br_tag = 1; br_mis = 0; #1;
    rfchk("R6", 0, 9, dv(8), 8); chk("R7", rf_we1, 0);
    chk("R7", st_we, 1); chk("R7", st_addr, 16'h0200); chk("R7", st_dat, 32'hCAFE0001);
    tick();
    // R9 correct branch retires silently
    #1;
    chk("R9", rf_we0, 0); chk("R9", rf_we1, 0); chk("R9", st_we, 0); chk("R9", flush, 0);
    tick();
    // R8 / R10 setup
    alloc_req0 = 1; alloc_req1 = 1; alloc_typ0 = 2'd2; alloc_typ1 = 2'd2;
    alloc_dst0 = 16'h0300; alloc_dst1 = 16'h0304; #1;
    chk("R9", alloc_ok, 1); chk("R2", alloc_tag0, 2); chk("R2", alloc_tag1, 3);
    tick();
    alloc_req0 = 1; alloc_req1 = 1; alloc_typ0 = 2'd3; alloc_typ1 = 2'd0; alloc_dst1 = 12; #1;
    chk("R2", alloc_tag0, 4); chk("R2", alloc_tag1, 5);
    tick();
    alloc_req0 = 1; alloc_typ0 = 2'd0; alloc_dst0 = 13;
    bus(2, 32'hA2, 3, 32'hA3); br_vld = 1; br_tag = 4; br_mis = 1; #1;
    chk("R2", alloc_tag0, 6);
    tick();
    bus(5, 32'h55, 6, 32'h66); #1;
    chk("R8", st_we, 1); chk("R8", st_addr, 16'h0300); chk("R8", st_dat, 32'hA2);
    chk("R8", rf_we1, 0); chk("R8", flush, 0);
    tick();
    alloc_req0 = 1; #1;
    chk("R8", st_we, 1); chk("R8", st_addr, 16'h0304); chk("R8", st_dat, 32'hA3);
    chk("R10", flush, 1); chk("R10", alloc_ok, 0); chk("R10", rf_we1, 0);
    tick();
    alloc_req0 = 1; alloc_req1 = 1; alloc_dst0 = 20; alloc_dst1 = 21; #1;
    chk("R10", rf_we0, 0); chk("R10", rf_we1, 0); chk("R10", st_we, 0); chk("R10", flush, 0);
    chk("R10", alloc_ok, 1); chk("R10", alloc_tag0, 5); chk("R10", alloc_tag1, 6);
    tick();
    bus(6, 32'h77, 5, 32'h88); #1;
    chk("R10", rf_we0, 0);
    tick();
    #1;
    rfchk("R4", 0, 20, 32'h88, 5); rfchk("R4", 1, 21, 32'h77, 6);
    tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule